// File: doc/BRIEF.md
# RTC Alarm and Interrupt Controller

This block sits beside a real-time-clock timebase. It watches the running seconds count and a one-cycle pulse that marks each new second. It keeps two interrupt sources: a per-second event and an alarm event. The alarm event fires when the freshly updated count equals a programmable 32-bit alarm value. Each source has a sticky status bit and an enable bit. The enable bit is changed only through a write-one-to-set register and a separate write-one-to-clear register, and it can be read back through a read-only mask view. Status bits are cleared by writing 1.

Software reaches the block through simple read and write strobes. Each interrupt output is high while its status bit and its enable bit are both set.

Top module: `rtc_alarm_irq_ctrl`

## Requirements
- R1: After synchronous reset, both status bits, both enable bits and the alarm value are 0, and both interrupt outputs are low.
- R2: The seconds status bit (status bit 0) sets in the cycle after each `tick` pulse and stays set until software clears it.
- R3: The alarm status bit (status bit 1) sets in the cycle after a `tick` pulse whose accompanying `sec_count` equals the alarm value. A matching count without a pulse, or a pulse with a different count, leaves it unchanged.
- R4: Writing the status register (offset 0x20) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Writing the enable-set register (offset 0x28) turns on each enable bit written as 1; bits written as 0 are unchanged.
- R6: Writing the enable-clear register (offset 0x2C) turns off each enable bit written as 1; bits written as 0 are unchanged.
- R7: Reading the mask register (offset 0x24) returns the enable bits in bits 1:0 (bit 0 seconds, bit 1 alarm) and 0 in all other bits. Writes to it have no effect.
- R8: The alarm register (offset 0x18) holds all 32 bits written and reads them back unchanged.
- R9: `irq_sec` equals status bit 0 AND enable bit 0, and `irq_alarm` equals status bit 1 AND enable bit 1, with no extra delay.
- R10: When a hardware set and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R11: Reads of the enable-set register, the enable-clear register and any unmapped offset return 0. Writes to unmapped offsets change no state.
- R12: Read data appears on `rd_data` in the cycle after `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse marking a new second |
| sec_count | input | CNT_W | Running seconds count, already updated while `tick` is high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench first runs through the register map. It targets write-zero writes to the set and clear registers, which a design that wrote the value straight into the enables would use to wipe the enables. It holds a count equal to the alarm value without a pulse, where a design that compared on every cycle would raise the alarm early. It writes the status register in the same cycle as a second pulse, where a design that gave the clear priority would lose the event. It also clears one status bit while the other stays set, which shows whether a clear spills over into the neighbouring bit.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;

    localparam int SRC_N   = 2;
    localparam int SRC_SEC = 0;
    localparam int SRC_ALM = 1;

    localparam logic [31:0] OFS_ALARM  = 32'h18;
    localparam logic [31:0] OFS_STATUS = 32'h20;
    localparam logic [31:0] OFS_MASK   = 32'h24;
    localparam logic [31:0] OFS_ENSET  = 32'h28;
    localparam logic [31:0] OFS_ENCLR  = 32'h2C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_STATUS,
        SEL_MASK,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    // per-source control strobes gathered from the register port
    typedef struct packed {
        src_vec_t sts_clr;
        src_vec_t en_set;
        src_vec_t en_clr;
    } src_ctl_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        case (ofs)
            OFS_ALARM:  return SEL_ALARM;
            OFS_STATUS: return SEL_STATUS;
            OFS_MASK:   return SEL_MASK;
            OFS_ENSET:  return SEL_ENSET;
            OFS_ENCLR:  return SEL_ENCLR;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rtcirq_alarm_match.sv
module rtcirq_alarm_match #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] sec_count,
    output logic [CNT_W-1:0] alarm_q,
    output logic             hit
);

    always_ff @(posedge clk) begin
        if (rst)
            alarm_q <= '0;
        else if (load)
            alarm_q <= load_val;
    end

    // compare only when the count has just advanced
    assign hit = tick && (sec_count == alarm_q);

endmodule

// File: rtl/rtcirq_src_bit.sv
module rtcirq_src_bit (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic sw_clr,
    input  logic en_set,
    input  logic en_clr,
    output logic sts_q,
    output logic en_q,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= 1'b0;
        else if (hw_set)
            sts_q <= 1'b1;
        else if (sw_clr)
            sts_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (en_set)
            en_q <= 1'b1;
        else if (en_clr)
            en_q <= 1'b0;
    end

    assign irq = sts_q & en_q;

endmodule

// File: rtl/rtcirq_readback.sv
module rtcirq_readback
    import rtcirq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [CNT_W-1:0]  alarm,
    input  src_vec_t          sts,
    input  src_vec_t          ena,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mux;

    always_comb begin
        case (sel)
            SEL_ALARM:  mux = DATA_W'(alarm);
            SEL_STATUS: mux = DATA_W'(sts);
            SEL_MASK:   mux = DATA_W'(ena);
            default:    mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= mux;
    end

endmodule

// File: rtl/rtc_alarm_irq_ctrl.sv
module rtc_alarm_irq_ctrl
    import rtcirq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CNT_W-1:0]  sec_count,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_sec,
    output logic              irq_alarm
);

    reg_sel_e         sel;
    src_ctl_t         ctl;
    src_vec_t         hw_set;
    src_vec_t         sts_bits;
    src_vec_t         ena_bits;
    src_vec_t         irq_bits;
    logic [CNT_W-1:0] alarm_val;
    logic             alarm_hit;

    assign sel = decode_ofs(32'(addr));

    always_comb begin
        ctl.sts_clr = (wr_en && sel == SEL_STATUS) ? wr_data[SRC_N-1:0] : '0;
        ctl.en_set  = (wr_en && sel == SEL_ENSET)  ? wr_data[SRC_N-1:0] : '0;
        ctl.en_clr  = (wr_en && sel == SEL_ENCLR)  ? wr_data[SRC_N-1:0] : '0;
    end

    rtcirq_alarm_match #(.CNT_W(CNT_W)) i_match (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en && sel == SEL_ALARM),
        .load_val (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .sec_count(sec_count),
        .alarm_q  (alarm_val),
        .hit      (alarm_hit)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[SRC_SEC] = tick;
        hw_set[SRC_ALM] = alarm_hit;
    end

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        rtcirq_src_bit i_bit (
            .clk   (clk),
            .rst   (rst),
            .hw_set(hw_set[s]),
            .sw_clr(ctl.sts_clr[s]),
            .en_set(ctl.en_set[s]),
            .en_clr(ctl.en_clr[s]),
            .sts_q (sts_bits[s]),
            .en_q  (ena_bits[s]),
            .irq   (irq_bits[s])
        );
    end

    rtcirq_readback #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_rb (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .sel    (sel),
        .alarm  (alarm_val),
        .sts    (sts_bits),
        .ena    (ena_bits),
        .rd_data(rd_data)
    );

    assign irq_sec   = irq_bits[SRC_SEC];
    assign irq_alarm = irq_bits[SRC_ALM];

endmodule

// File: rtl/rtcirq_checker.sv
module rtcirq_checker
    import rtcirq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [CNT_W-1:0]  sec_count,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_sec,
    input logic              irq_alarm,
    input src_vec_t          sts,
    input src_vec_t          ena,
    input logic [CNT_W-1:0]  alarm
);

    logic wr_sts, wr_set, wr_clr, match;
    assign wr_sts = wr_en && (32'(addr) == OFS_STATUS);
    assign wr_set = wr_en && (32'(addr) == OFS_ENSET);
    assign wr_clr = wr_en && (32'(addr) == OFS_ENCLR);
    assign match  = tick && (sec_count == alarm);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (sts == '0 && ena == '0 && alarm == '0 && !irq_sec && !irq_alarm));

    p_sec_set_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> sts[SRC_SEC]);

    p_alarm_hit_r3: assert property (@(posedge clk) disable iff (rst)
        match |=> sts[SRC_ALM]);

    p_alarm_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!sts[SRC_ALM] && !match) |=> !sts[SRC_ALM]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && wr_data[SRC_SEC] && !tick) |=> !sts[SRC_SEC]);

    p_enset_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_set && wr_data[SRC_ALM]) |=> ena[SRC_ALM]);

    p_enclr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && wr_data[SRC_ALM]) |=> !ena[SRC_ALM]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !ena[SRC_SEC] |-> !irq_sec);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (match && wr_sts && wr_data[SRC_ALM]) |=> sts[SRC_ALM]);

endmodule

bind rtc_alarm_irq_ctrl rtcirq_checker #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sec_count(sec_count),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .irq_sec  (irq_sec),
    .irq_alarm(irq_alarm),
    .sts      (sts_bits),
    .ena      (ena_bits),
    .alarm    (alarm_val)
);

// File: tb/test_rtc_alarm_irq_ctrl.sv
module test_rtc_alarm_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [31:0] sec_count;
    logic        wr_en;
    logic        rd_en;
    logic [7:0]  addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq_sec;
    logic        irq_alarm;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_alarm_irq_ctrl i_rtc_alarm_irq_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .sec_count(sec_count),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
    );

    // entry: {is_write, offset, data, expected read value}
    localparam int NV = 16;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h18, 32'hDEADBEEF, 32'h0},        // R8 load alarm
        {1'b0, 8'h18, 32'h0,        32'hDEADBEEF}, // R8, R12 read back
        {1'b1, 8'h28, 32'h3,        32'h0},        // R5 enable both
        {1'b0, 8'h24, 32'h0,        32'h3},        // R5, R7
        {1'b1, 8'h2C, 32'h1,        32'h0},        // R6 drop seconds
        {1'b0, 8'h24, 32'h0,        32'h2},        // R6, R7
        {1'b1, 8'h28, 32'h0,        32'h0},        // R5 zero write
        {1'b0, 8'h24, 32'h0,        32'h2},        // R5 unchanged
        {1'b1, 8'h2C, 32'h0,        32'h0},        // R6 zero write
        {1'b0, 8'h24, 32'h0,        32'h2},        // R6 unchanged
        {1'b0, 8'h28, 32'h0,        32'h0},        // R11 set reg reads 0
        {1'b0, 8'h2C, 32'h0,        32'h0},        // R11 clr reg reads 0
        {1'b1, 8'h30, 32'hFFFFFFFF, 32'h0},        // R11 unmapped write
        {1'b0, 8'h30, 32'h0,        32'h0},        // R11 unmapped read
        {1'b1, 8'h24, 32'h0,        32'h0},        // R7 mask is read-only
        {1'b0, 8'h24, 32'h0,        32'h2}         // R7 unchanged
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [31:0] c);
        @(negedge clk);
        tick = 1'b1; sec_count = c;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; tick = 1'b0; sec_count = '0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {30'd0, irq_alarm, irq_sec}, 32'h0);
        rd(8'h20, v); check("R1 status", v, 32'h0);
        rd(8'h24, v); check("R1 mask", v, 32'h0);
        rd(8'h18, v); check("R1 alarm", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                check("R5/R6/R7/R8/R11 table", v, VEC[i][31:0]);
            end
        end

        // R12 read data holds without rd_en
        repeat (2) @(negedge clk);
        check("R12 hold", rd_data, 32'h2);

        wr(8'h2C, 32'h3);
        wr(8'h18, 32'd100);
        wr(8'h20, 32'h3);
        pulse(32'd99);
        rd(8'h20, v); check("R2 R3 mismatch tick", v, 32'h1);
        check("R9 disabled sec", {31'd0, irq_sec}, 32'h0);
        wr(8'h28, 32'h1);
        check("R9 enabled sec", {31'd0, irq_sec}, 32'h1);
        wr(8'h2C, 32'h1);
        check("R9 disabled again", {31'd0, irq_sec}, 32'h0);
        wr(8'h20, 32'h2);
        rd(8'h20, v); check("R4 zero bit kept", v, 32'h1);
        wr(8'h20, 32'h1);
        rd(8'h20, v); check("R4 cleared", v, 32'h0);

        // R3 matching count held without a pulse
        @(negedge clk); sec_count = 32'd100;
        repeat (3) @(negedge clk);
        rd(8'h20, v); check("R3 no pulse", v, 32'h0);
        pulse(32'd100);
        rd(8'h20, v); check("R2 R3 alarm hit", v, 32'h3);
        wr(8'h28, 32'h2);
        check("R9 alarm irq", {30'd0, irq_alarm, irq_sec}, 32'h2);

        // R10 set beats clear in the same cycle
        @(negedge clk);
        tick = 1'b1; sec_count = 32'd100;
        wr_en = 1'b1; addr = 8'h20; wr_data = 32'h3;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(8'h20, v); check("R10 set wins", v, 32'h3);
        wr(8'h20, 32'h3);
        rd(8'h20, v); check("R4 both cleared", v, 32'h0);
        check("R9 irq low", {30'd0, irq_alarm, irq_sec}, 32'h0);

        // R1 reset during operation
        pulse(32'd5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 irq after reset", {30'd0, irq_alarm, irq_sec}, 32'h0);
        rd(8'h24, v); check("R1 mask after reset", v, 32'h0);
        rd(8'h18, v); check("R1 alarm after reset", v, 32'h0);
        rd(8'h20, v); check("R1 status after reset", v, 32'h0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule